// File: doc/BRIEF.md
# GPIO Bank With Dual Interrupt Channels

A 32-pin general-purpose I/O bank controlled through a 32-bit register port. Each pin is either driven from a data-out register or observed as an input, chosen by a per-pin output-enable register in which a 1 means "input". The data-out, interrupt-enable and wakeup-enable registers also have clear and set alias addresses. These update single bits atomically, so software never needs a read-modify-write sequence.

Input pins can raise events in four ways, each chosen by its own mask: while the pin is high, while it is low, on a rising edge or on a falling edge. Edges are found by comparing the pin with the sample taken on the previous clock. An event sets the pin's bit in the status registers of both interrupt channels. Each channel has its own enable register and its own interrupt output. A one-cycle wakeup pulse is produced for wake-enabled pins when the configuration register allows it.

Writes can be byte, halfword or word sized. On an ordinary register, a narrow write changes only its lane and keeps the rest. On a status or alias register, the lane-shifted value is used alone.

Top module: `gpio_bank`

## Requirements
- R1: After reset, the registers read as follows: revision (0x00) returns the REVISION parameter, status-ready (0x14) returns 1, configuration (0x10) 0, control (0x30) 2, output enable (0x34) all ones. Data out, both status registers, both enables, wakeup enable, all detect masks and both debounce registers read 0.
- R2: `pinDriveEn` is the bitwise inverse of the output-enable register, and `pinOut` equals the data-out register (0x3C).
- R3: Address 0x38 returns the pin levels sampled on the previous clock. Writes to 0x00, 0x14 and 0x38 change nothing.
- R4: For a pin whose output-enable bit is 1, the pin being high with its level-high mask bit set (0x44), or low with its level-low mask bit set (0x40), sets that bit in both status registers (0x18 and 0x28) at the next clock. Pins with output-enable 0 never set status.
- R5: For an input pin, a 0-to-1 change between consecutive samples with its rising mask bit set (0x48) sets its status bits, and a 1-to-0 change with its falling mask bit set (0x4C) does the same.
- R6: `irqCh1` is high exactly when status 0x18 ANDed with enable 0x1C is nonzero. `irqCh2` follows status 0x28 and enable 0x2C in the same way.
- R7: Writing 1s to a status register clears those bits in that channel only. A pin whose level condition still holds is set again, because an event in the same cycle wins over the clear.
- R8: The alias addresses clear (first) or set (second) the written 1-bits: 0x60/0x64 for enable 1, 0x70/0x74 for enable 2, 0x80/0x84 for wakeup enable, 0x90/0x94 for data out. A read of an alias returns the underlying register.
- R9: `wakePulse` is high for one cycle, one clock after an event arises on a pin whose wakeup-enable bit (0x20) is 1. This happens only while configuration bit 2 is 1 and configuration bits 4:3 are nonzero. Events that continue without a break give a single pulse.
- R10: The configuration register stores only the bits in mask 0x1D, and the control register stores only its low 3 bits. A configuration write with bit 1 set returns every register to its R1 value, except data out, before the new value is stored.
- R11: busSize 0 writes the low byte of busWrData to byte lane busAddr[1:0]. busSize 1 writes the low halfword to halfword lane busAddr[1]. busSize 2 or 3 writes the whole word. Ordinary registers keep their bits outside the lane. Status and alias registers receive the shifted value with zeros outside the lane.
- R12: Debounce enable (0x50) stores 32 bits and debounce time (0x54) stores 8 bits. Neither changes any other behaviour.
- R13: Writes to unmapped addresses change nothing, and reads of them return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busWrEn | input | 1 | Write strobe, one cycle per write |
| busAddr | input | 8 | Write byte address |
| busSize | input | 2 | Write size: 0 byte, 1 halfword, 2/3 word |
| busWrData | input | 32 | Write data, right-aligned for narrow writes |
| busRdAddr | input | 8 | Read address (word-aligned, low bits ignored) |
| busRdData | output | 32 | Read data, combinational from busRdAddr |
| pinIn | input | 32 | Pin levels, synchronous to clk |
| pinOut | output | 32 | Output data for the pins |
| pinDriveEn | output | 32 | Per-pin drive enable |
| irqCh1 | output | 1 | Interrupt of channel 1 |
| irqCh2 | output | 1 | Interrupt of channel 2 |
| wakePulse | output | 1 | One-cycle wakeup request |

## Verification
A wrong stored register shows up on the read port as soon as the write has been clocked in. For data out and output enable it also appears at once on `pinOut` and `pinDriveEn`. A wrong edge sample or a wrong detect decode shows up one clock after the pin change, as a missing or extra status bit in both channels and as a change on the interrupt outputs. A bad lane merge corrupts neighbouring bytes, which are read back straight after a narrow write. A merge wrongly applied to an alias clears or sets bits outside the addressed lane.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam int BANK_W = 32;
  localparam int OFF_W  = 8;

  localparam logic [OFF_W-1:0] A_REV     = 8'h00;
  localparam logic [OFF_W-1:0] A_SYSCFG  = 8'h10;
  localparam logic [OFF_W-1:0] A_READY   = 8'h14;
  localparam logic [OFF_W-1:0] A_STAT1   = 8'h18;
  localparam logic [OFF_W-1:0] A_EN1     = 8'h1C;
  localparam logic [OFF_W-1:0] A_WAKE    = 8'h20;
  localparam logic [OFF_W-1:0] A_STAT2   = 8'h28;
  localparam logic [OFF_W-1:0] A_EN2     = 8'h2C;
  localparam logic [OFF_W-1:0] A_CTRL    = 8'h30;
  localparam logic [OFF_W-1:0] A_OE      = 8'h34;
  localparam logic [OFF_W-1:0] A_DIN     = 8'h38;
  localparam logic [OFF_W-1:0] A_DOUT    = 8'h3C;
  localparam logic [OFF_W-1:0] A_LVLLO   = 8'h40;
  localparam logic [OFF_W-1:0] A_LVLHI   = 8'h44;
  localparam logic [OFF_W-1:0] A_RISE    = 8'h48;
  localparam logic [OFF_W-1:0] A_FALL    = 8'h4C;
  localparam logic [OFF_W-1:0] A_DBEN    = 8'h50;
  localparam logic [OFF_W-1:0] A_DBTIME  = 8'h54;
  localparam logic [OFF_W-1:0] A_EN1CLR  = 8'h60;
  localparam logic [OFF_W-1:0] A_EN1SET  = 8'h64;
  localparam logic [OFF_W-1:0] A_EN2CLR  = 8'h70;
  localparam logic [OFF_W-1:0] A_EN2SET  = 8'h74;
  localparam logic [OFF_W-1:0] A_WAKECLR = 8'h80;
  localparam logic [OFF_W-1:0] A_WAKESET = 8'h84;
  localparam logic [OFF_W-1:0] A_DOUTCLR = 8'h90;
  localparam logic [OFF_W-1:0] A_DOUTSET = 8'h94;

  localparam logic [4:0] SYSCFG_KEEP = 5'h1D;
  localparam logic [2:0] CTRL_INIT   = 3'd2;

  typedef enum logic [1:0] {SZ_BYTE = 2'd0, SZ_HALF = 2'd1, SZ_WORD = 2'd2} wsize_e;

  typedef struct packed {
    logic sysCfg;
    logic ctrl;
    logic oe;
    logic dout;
    logic doutClr;
    logic doutSet;
    logic lvlLo;
    logic lvlHi;
    logic rise;
    logic fall;
    logic dbEn;
    logic dbTime;
    logic wakeWr;
    logic wakeClr;
    logic wakeSet;
    logic [1:0] statClr;
    logic [1:0] enWr;
    logic [1:0] enClr;
    logic [1:0] enSet;
  } wr_strobe_t;
endpackage

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl
  import gpio_bank_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWrEn,
  input  logic [OFF_W-1:0]  busAddr,
  input  logic [1:0]        busSize,
  input  logic [BANK_W-1:0] busWrData,
  input  logic [BANK_W-1:0] curVal,
  output logic [OFF_W-1:0]  lookupAddr,
  output wr_strobe_t        stb,
  output logic [BANK_W-1:0] wrVal
);
  localparam int LANE_SH = $clog2(BANK_W / 8);

  logic [BANK_W-1:0] laneMask;
  logic [BANK_W-1:0] shifted;
  logic              direct;

  assign lookupAddr = {busAddr[OFF_W-1:LANE_SH], {LANE_SH{1'b0}}};

  always_comb begin
    case (busSize)
      SZ_BYTE: begin
        laneMask = BANK_W'(32'hFF) << {busAddr[1:0], 3'b000};
        shifted  = BANK_W'(busWrData[7:0]) << {busAddr[1:0], 3'b000};
      end
      SZ_HALF: begin
        laneMask = BANK_W'(32'hFFFF) << {busAddr[1], 4'b0000};
        shifted  = BANK_W'(busWrData[15:0]) << {busAddr[1], 4'b0000};
      end
      default: begin
        laneMask = '1;
        shifted  = busWrData;
      end
    endcase
  end

  always_comb begin
    case (lookupAddr)
      A_STAT1, A_STAT2, A_EN1CLR, A_EN1SET, A_EN2CLR, A_EN2SET,
      A_WAKECLR, A_WAKESET, A_DOUTCLR, A_DOUTSET: direct = 1'b1;
      default: direct = 1'b0;
    endcase
  end

  assign wrVal = direct ? shifted : ((curVal & ~laneMask) | (shifted & laneMask));

  always_comb begin
    stb = '0;
    if (busWrEn) begin
      case (lookupAddr)
        A_SYSCFG:  stb.sysCfg     = 1'b1;
        A_CTRL:    stb.ctrl       = 1'b1;
        A_OE:      stb.oe         = 1'b1;
        A_DOUT:    stb.dout       = 1'b1;
        A_DOUTCLR: stb.doutClr    = 1'b1;
        A_DOUTSET: stb.doutSet    = 1'b1;
        A_LVLLO:   stb.lvlLo      = 1'b1;
        A_LVLHI:   stb.lvlHi      = 1'b1;
        A_RISE:    stb.rise       = 1'b1;
        A_FALL:    stb.fall       = 1'b1;
        A_DBEN:    stb.dbEn       = 1'b1;
        A_DBTIME:  stb.dbTime     = 1'b1;
        A_WAKE:    stb.wakeWr     = 1'b1;
        A_WAKECLR: stb.wakeClr    = 1'b1;
        A_WAKESET: stb.wakeSet    = 1'b1;
        A_STAT1:   stb.statClr[0] = 1'b1;
        A_STAT2:   stb.statClr[1] = 1'b1;
        A_EN1:     stb.enWr[0]    = 1'b1;
        A_EN2:     stb.enWr[1]    = 1'b1;
        A_EN1CLR:  stb.enClr[0]   = 1'b1;
        A_EN2CLR:  stb.enClr[1]   = 1'b1;
        A_EN1SET:  stb.enSet[0]   = 1'b1;
        A_EN2SET:  stb.enSet[1]   = 1'b1;
        default: ;
      endcase
    end
  end

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(stb)); // R13
  AST_DIRECT_LANE_ONLY: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && (stb.statClr != 2'b00 || stb.doutClr || stb.doutSet))
      |-> (wrVal & ~laneMask) == '0); // R11
endmodule

// File: rtl/gpio_bank_dp.sv
module gpio_bank_dp
  import gpio_bank_pkg::*;
#(
  parameter logic [7:0] REVISION = 8'h25,
  parameter int         DBT_W    = 8,
  parameter int         NUM_CH   = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  wr_strobe_t        stb,
  input  logic [BANK_W-1:0] wrVal,
  input  logic [OFF_W-1:0]  lookupAddr,
  output logic [BANK_W-1:0] curVal,
  input  logic [OFF_W-1:0]  rdAddr,
  output logic [BANK_W-1:0] rdData,
  input  logic [BANK_W-1:0] pinIn,
  output logic [BANK_W-1:0] pinOut,
  output logic [BANK_W-1:0] pinDriveEn,
  output logic [NUM_CH-1:0] irq,
  output logic              wakePulse
);
  logic [4:0]        sysCfgQ;
  logic [2:0]        ctrlQ;
  logic [BANK_W-1:0] oeQ, doutQ, lvlLoQ, lvlHiQ, riseQ, fallQ, dbEnQ, wakeEnQ;
  logic [DBT_W-1:0]  dbTimeQ;
  logic [BANK_W-1:0] sampleQ;
  logic              sampleValidQ;
  logic              wakeReqQ, wakePulseQ;
  logic [BANK_W-1:0] statQ [NUM_CH];
  logic [BANK_W-1:0] enQ   [NUM_CH];
  logic [BANK_W-1:0] evt;
  logic              softRst, wakeReq;

  assign softRst = stb.sysCfg & wrVal[1];

  // edge and level detection on input pins
  always_comb begin
    logic [BANK_W-1:0] edges;
    edges = sampleValidQ ? ((pinIn & ~sampleQ & riseQ) | (~pinIn & sampleQ & fallQ)) : '0;
    evt   = oeQ & (edges | (pinIn & lvlHiQ) | (~pinIn & lvlLoQ));
  end

  assign wakeReq = sysCfgQ[2] & (sysCfgQ[4:3] != 2'b00) & ((evt & wakeEnQ) != '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sampleQ      <= '0;
      sampleValidQ <= 1'b0;
      doutQ        <= '0;
    end else begin
      sampleQ      <= pinIn;
      sampleValidQ <= 1'b1;
      if (stb.dout)         doutQ <= wrVal;
      else if (stb.doutClr) doutQ <= doutQ & ~wrVal;
      else if (stb.doutSet) doutQ <= doutQ | wrVal;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || softRst) begin
      sysCfgQ    <= (!rstN) ? 5'd0 : (wrVal[4:0] & SYSCFG_KEEP);
      ctrlQ      <= CTRL_INIT;
      oeQ        <= '1;
      lvlLoQ     <= '0;
      lvlHiQ     <= '0;
      riseQ      <= '0;
      fallQ      <= '0;
      dbEnQ      <= '0;
      dbTimeQ    <= '0;
      wakeEnQ    <= '0;
      wakeReqQ   <= 1'b0;
      wakePulseQ <= 1'b0;
    end else begin
      if (stb.sysCfg) sysCfgQ <= wrVal[4:0] & SYSCFG_KEEP;
      if (stb.ctrl)   ctrlQ   <= wrVal[2:0];
      if (stb.oe)     oeQ     <= wrVal;
      if (stb.lvlLo)  lvlLoQ  <= wrVal;
      if (stb.lvlHi)  lvlHiQ  <= wrVal;
      if (stb.rise)   riseQ   <= wrVal;
      if (stb.fall)   fallQ   <= wrVal;
      if (stb.dbEn)   dbEnQ   <= wrVal;
      if (stb.dbTime) dbTimeQ <= wrVal[DBT_W-1:0];
      if (stb.wakeWr)       wakeEnQ <= wrVal;
      else if (stb.wakeClr) wakeEnQ <= wakeEnQ & ~wrVal;
      else if (stb.wakeSet) wakeEnQ <= wakeEnQ | wrVal;
      wakeReqQ   <= wakeReq;
      wakePulseQ <= wakeReq & ~wakeReqQ;
    end
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
    always_ff @(posedge clk) begin
      if (!rstN || softRst) begin
        statQ[c] <= '0;
        enQ[c]   <= '0;
      end else begin
        statQ[c] <= (statQ[c] & ~(stb.statClr[c] ? wrVal : '0)) | evt;
        if (stb.enWr[c])       enQ[c] <= wrVal;
        else if (stb.enClr[c]) enQ[c] <= enQ[c] & ~wrVal;
        else if (stb.enSet[c]) enQ[c] <= enQ[c] | wrVal;
      end
    end
    assign irq[c] = (statQ[c] & enQ[c]) != '0;

    AST_STATUS_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
      (stb.statClr[c] && !softRst) |=> ((statQ[c] & $past(wrVal) & ~$past(evt)) == '0)); // R7
    AST_EVENT_SETS_STATUS: assert property (@(posedge clk) disable iff (!rstN)
      (evt != '0 && !softRst) |=> ((statQ[c] & $past(evt)) == $past(evt))); // R4
    AST_NO_OUTPUT_EVENT: assert property (@(posedge clk) disable iff (!rstN)
      $past(rstN) |-> ((statQ[c] & ~$past(statQ[c]) & ~$past(oeQ)) == '0)); // R4
  end

  function automatic logic [BANK_W-1:0] regRead(input logic [OFF_W-1:0] a);
    case (a)
      A_REV:                         regRead = BANK_W'(REVISION);
      A_SYSCFG:                      regRead = BANK_W'(sysCfgQ);
      A_READY:                       regRead = BANK_W'(1);
      A_STAT1:                       regRead = statQ[0];
      A_STAT2:                       regRead = statQ[1];
      A_EN1, A_EN1CLR, A_EN1SET:     regRead = enQ[0];
      A_EN2, A_EN2CLR, A_EN2SET:     regRead = enQ[1];
      A_WAKE, A_WAKECLR, A_WAKESET:  regRead = wakeEnQ;
      A_CTRL:                        regRead = BANK_W'(ctrlQ);
      A_OE:                          regRead = oeQ;
      A_DIN:                         regRead = sampleQ;
      A_DOUT, A_DOUTCLR, A_DOUTSET:  regRead = doutQ;
      A_LVLLO:                       regRead = lvlLoQ;
      A_LVLHI:                       regRead = lvlHiQ;
      A_RISE:                        regRead = riseQ;
      A_FALL:                        regRead = fallQ;
      A_DBEN:                        regRead = dbEnQ;
      A_DBTIME:                      regRead = BANK_W'(dbTimeQ);
      default:                       regRead = '0;
    endcase
  endfunction

  assign curVal     = regRead(lookupAddr);
  assign rdData     = regRead({rdAddr[OFF_W-1:2], 2'b00});
  assign pinOut     = doutQ;
  assign pinDriveEn = ~oeQ;
  assign wakePulse  = wakePulseQ;

  AST_WAKE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    wakePulseQ |=> !wakePulseQ); // R9
  AST_WAKE_GATED: assert property (@(posedge clk) disable iff (!rstN)
    (wakePulseQ && $past(rstN)) |-> ($past(sysCfgQ[2]) && $past(sysCfgQ[4:3]) != 2'b00)); // R9
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
  import gpio_bank_pkg::*;
#(
  parameter logic [7:0] REVISION = 8'h25,
  parameter int         DBT_W    = 8
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        busWrEn,
  input  logic [7:0]  busAddr,
  input  logic [1:0]  busSize,
  input  logic [31:0] busWrData,
  input  logic [7:0]  busRdAddr,
  output logic [31:0] busRdData,
  input  logic [31:0] pinIn,
  output logic [31:0] pinOut,
  output logic [31:0] pinDriveEn,
  output logic        irqCh1,
  output logic        irqCh2,
  output logic        wakePulse
);
  localparam int NUM_CH = 2;

  wr_strobe_t        stb;
  logic [BANK_W-1:0] wrVal, curVal;
  logic [OFF_W-1:0]  lookupAddr;
  logic [NUM_CH-1:0] irq;

  gpio_bank_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .busWrEn    (busWrEn),
    .busAddr    (busAddr),
    .busSize    (busSize),
    .busWrData  (busWrData),
    .curVal     (curVal),
    .lookupAddr (lookupAddr),
    .stb        (stb),
    .wrVal      (wrVal)
  );

  gpio_bank_dp #(.REVISION(REVISION), .DBT_W(DBT_W), .NUM_CH(NUM_CH)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .stb        (stb),
    .wrVal      (wrVal),
    .lookupAddr (lookupAddr),
    .curVal     (curVal),
    .rdAddr     (busRdAddr),
    .rdData     (busRdData),
    .pinIn      (pinIn),
    .pinOut     (pinOut),
    .pinDriveEn (pinDriveEn),
    .irq        (irq),
    .wakePulse  (wakePulse)
  );

  assign irqCh1 = irq[0];
  assign irqCh2 = irq[1];
endmodule

// File: tb/gpio_bank_bench.sv
module gpio_bank_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busWrEn = 1'b0;
  logic [7:0]  busAddr = '0;
  logic [1:0]  busSize = 2'd2;
  logic [31:0] busWrData = '0;
  logic [7:0]  busRdAddr = '0;
  logic [31:0] busRdData;
  logic [31:0] pinIn = '0;
  logic [31:0] pinOut, pinDriveEn;
  logic        irqCh1, irqCh2, wakePulse;

  int errors = 0;
  int checks = 0;
  int wakeCnt = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_bank u_gpio_bank (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busAddr(busAddr), .busSize(busSize),
    .busWrData(busWrData), .busRdAddr(busRdAddr), .busRdData(busRdData), .pinIn(pinIn),
    .pinOut(pinOut), .pinDriveEn(pinDriveEn), .irqCh1(irqCh1), .irqCh2(irqCh2),
    .wakePulse(wakePulse)
  );

  always @(negedge clk) if (rstN && wakePulse) wakeCnt++;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic [1:0] sz = 2'd2);
    @(negedge clk);
    busWrEn = 1'b1; busAddr = a; busWrData = d; busSize = sz;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    busRdAddr = a;
    #1;
    d = busRdData;
  endtask

  task automatic rdChk(input string req, input logic [7:0] a, input logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    chk(req, v, exp);
  endtask

  // expected value of an ordinary register after a narrow write
  function automatic logic [31:0] mergeExp(input logic [31:0] old, input logic [31:0] d,
                                           input logic [1:0] sz, input logic [1:0] lo);
    logic [31:0] m;
    logic [31:0] v;
    if (sz == 2'd0) begin
      m = 32'hFF << (8 * lo); v = {24'b0, d[7:0]} << (8 * lo);
    end else if (sz == 2'd1) begin
      m = 32'hFFFF << (16 * lo[1]); v = {16'b0, d[15:0]} << (16 * lo[1]);
    end else begin
      m = '1; v = d;
    end
    return (old & ~m) | (v & m);
  endfunction

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] mdl [5];
    logic [7:0]  addrs [5];
    int c0;
    addrs[0] = 8'h20; addrs[1] = 8'h3C; addrs[2] = 8'h48; addrs[3] = 8'h4C; addrs[4] = 8'h50;
    void'($urandom(32'd20240611));
    cyc(3);
    rstN = 1'b1;
    cyc(1);

    // R1 reset state
    rdChk("R1 revision", 8'h00, 32'h25);
    rdChk("R1 ready", 8'h14, 32'h1);
    rdChk("R1 sysconfig", 8'h10, 32'h0);
    rdChk("R1 control", 8'h30, 32'h2);
    rdChk("R1 oe", 8'h34, 32'hFFFF_FFFF);
    rdChk("R1 stat1", 8'h18, 32'h0);
    rdChk("R1 en2", 8'h2C, 32'h0);
    rdChk("R1 dout", 8'h3C, 32'h0);
    chk("R1 irq", {30'b0, irqCh2, irqCh1}, 32'h0);

    // R2 pins follow oe and dout
    wr(8'h34, 32'hFFFF_0000);
    wr(8'h3C, 32'h1234_ABCD);
    chk("R2 drive", pinDriveEn, 32'h0000_FFFF);
    chk("R2 out", pinOut, 32'h1234_ABCD);

    // R3 sampled input, read-only registers
    pinIn = 32'hA5A5_0000;
    cyc(1);
    rdChk("R3 data in", 8'h38, 32'hA5A5_0000);
    wr(8'h38, 32'h0);
    wr(8'h00, 32'hFF);
    wr(8'h14, 32'h0);
    rdChk("R3 data in after write", 8'h38, 32'hA5A5_0000);
    rdChk("R3 revision after write", 8'h00, 32'h25);
    rdChk("R3 ready after write", 8'h14, 32'h1);

    // R10 soft reset, masks
    pinIn = 32'h0;
    wr(8'h1C, 32'hFF);
    wr(8'h30, 32'hFF);
    rdChk("R10 control masked", 8'h30, 32'h7);
    wr(8'h10, 32'h02);
    rdChk("R10 soft reset en1", 8'h1C, 32'h0);
    rdChk("R10 soft reset control", 8'h30, 32'h2);
    rdChk("R10 soft reset oe", 8'h34, 32'hFFFF_FFFF);
    rdChk("R10 dout kept", 8'h3C, 32'h1234_ABCD);
    wr(8'h10, 32'hFD);
    rdChk("R10 sysconfig masked", 8'h10, 32'h1D);
    wr(8'h10, 32'h00);

    // R4 level detect; pin 5 is an output
    wr(8'h34, ~32'h20);
    wr(8'h44, 32'h28);
    pinIn = 32'h28;
    cyc(2);
    rdChk("R4 stat1 level-high", 8'h18, 32'h08);
    rdChk("R4 stat2 level-high", 8'h28, 32'h08);
    wr(8'h40, 32'h4);
    cyc(1);
    rdChk("R4 level-low", 8'h18, 32'h0C);
    wr(8'h40, 32'h0);

    // R6 channel outputs
    chk("R6 irq1 disabled", {31'b0, irqCh1}, 32'h0);
    wr(8'h64, 32'h08);
    chk("R6 irq1 enabled", {31'b0, irqCh1}, 32'h1);
    chk("R6 irq2 still off", {31'b0, irqCh2}, 32'h0);
    wr(8'h2C, 32'h08);
    chk("R6 irq2 enabled", {31'b0, irqCh2}, 32'h1);

    // R7 clear with level still true, then with level gone
    wr(8'h18, 32'hFFFF_FFFF);
    rdChk("R7 level re-armed", 8'h18, 32'h08);
    pinIn = 32'h0;
    cyc(1);
    wr(8'h18, 32'hFFFF_FFFF);
    rdChk("R7 stat1 cleared", 8'h18, 32'h0);
    chk("R7 irq1 low", {31'b0, irqCh1}, 32'h0);
    rdChk("R7 stat2 kept", 8'h28, 32'h0C);
    chk("R7 irq2 high", {31'b0, irqCh2}, 32'h1);
    wr(8'h28, 32'hFFFF_FFFF);
    wr(8'h44, 32'h0);

    // R5 edges
    wr(8'h48, 32'h1);
    pinIn = 32'h1;
    cyc(1);
    rdChk("R5 rising", 8'h18, 32'h1);
    rdChk("R5 rising ch2", 8'h28, 32'h1);
    wr(8'h18, 32'hFFFF_FFFF);
    wr(8'h28, 32'hFFFF_FFFF);
    rdChk("R5 no repeat without edge", 8'h18, 32'h0);
    wr(8'h4C, 32'h2);
    pinIn = 32'h3;
    cyc(2);
    rdChk("R5 rise unmasked pin", 8'h18, 32'h0);
    pinIn = 32'h1;
    cyc(1);
    rdChk("R5 falling", 8'h18, 32'h2);
    wr(8'h18, 32'hFFFF_FFFF);

    // R9 wakeup
    wr(8'h10, 32'h0C);
    wr(8'h84, 32'h10);
    wr(8'h48, 32'h10);
    c0 = wakeCnt;
    pinIn = 32'h11;
    cyc(3);
    chk("R9 wake pulse", wakeCnt - c0, 32'd1);
    pinIn = 32'h01;
    wr(8'h10, 32'h04);
    c0 = wakeCnt;
    pinIn = 32'h11;
    cyc(3);
    chk("R9 gated by mode bits", wakeCnt - c0, 32'd0);
    pinIn = 32'h01;
    wr(8'h10, 32'h0C);
    wr(8'h80, 32'h10);
    rdChk("R8 wake alias read", 8'h84, 32'h0);
    c0 = wakeCnt;
    pinIn = 32'h11;
    cyc(3);
    chk("R9 gated by pin enable", wakeCnt - c0, 32'd0);
    wr(8'h10, 32'h0);

    // R8 aliases
    wr(8'h3C, 32'hF0F0_F0F0);
    wr(8'h94, 32'h0000_000F);
    rdChk("R8 dout set", 8'h3C, 32'hF0F0_F0FF);
    wr(8'h90, 32'hF000_0000);
    rdChk("R8 dout clear", 8'h90, 32'h00F0_F0FF);
    chk("R8 pins", pinOut, 32'h00F0_F0FF);
    wr(8'h74, 32'h0000_0300);
    wr(8'h70, 32'h0000_0100);
    rdChk("R8 en2 set/clear", 8'h74, 32'h0000_0208);

    // R11 narrow writes
    wr(8'h50, 32'h1122_3344);
    wr(8'h51, 32'h0000_00AB, 2'd0);
    rdChk("R11 byte merge", 8'h50, 32'h1122_AB44);
    wr(8'h52, 32'h0000_BEEF, 2'd1);
    rdChk("R11 half merge", 8'h50, 32'hBEEF_AB44);
    wr(8'h3C, 32'h0000_00F0);
    wr(8'h91, 32'h0000_00FF, 2'd0);
    rdChk("R11 alias no merge", 8'h3C, 32'h0000_00F0);
    wr(8'h97, 32'h0000_0001, 2'd0);
    rdChk("R11 alias lane 3", 8'h3C, 32'h0100_00F0);

    // R12 debounce storage
    wr(8'h54, 32'h0000_01FF);
    rdChk("R12 debounce time width", 8'h54, 32'h0000_00FF);

    // R13 unmapped
    wr(8'hA0, 32'hFFFF_FFFF);
    rdChk("R13 unmapped read", 8'hA0, 32'h0);
    rdChk("R13 gap read", 8'h04, 32'h0);
    rdChk("R13 dout untouched", 8'h3C, 32'h0100_00F0);

    // R11/R2 random narrow writes on ordinary registers
    for (int i = 0; i < 5; i++) begin
      mdl[i] = $urandom;
      wr(addrs[i], mdl[i]);
    end
    for (int n = 0; n < 300; n++) begin
      int k;
      logic [1:0]  sz;
      logic [1:0]  lo;
      logic [31:0] d;
      logic [31:0] v;
      k  = $urandom_range(4, 0);
      sz = 2'($urandom_range(3, 0));
      lo = 2'($urandom_range(3, 0));
      d  = $urandom;
      wr(addrs[k] | {6'b0, lo}, d, sz);
      mdl[k] = mergeExp(mdl[k], d, sz, lo);
      rd(addrs[k], v);
      chk("R11 random merge", v, mdl[k]);
      if (k == 1) chk("R2 random pin out", pinOut, mdl[1]);
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule